// File: doc/BRIEF.md
# Link Equalization Phase Controller

This block sequences the top-rate equalization phases for one end of a serial link. A single input selects whether the port plays the downstream or the upstream role. Once a request arrives while the link already runs at the 32GT/s rate, the controller steps through equalization phases 0 to 3. It picks the phase value to advertise and the kind of training ordered set the transmitter should send. It also watches the phase values the far side advertises. When the closing ordered sets and a stretch of idle traffic are complete, it hands off to normal operation. A phase that overstays its window is abandoned with a fail pulse, and the controller returns to the recovery entry state.

Received ordered sets arrive as single-cycle strobes that carry a phase, a type and an error-free flag. The controller accepts one on every cycle and applies no back-pressure, so the framing logic upstream of it never stalls. All other pins are plain control and status levels or pulses. Analog tuning, serialization and ordered-set framing belong to neighbouring blocks.

Top module: `eq_phase_ctrl`

## Requirements
- R1: A request (`eq_start`) made in the recovery entry state or the operational state is refused when `cur_rate` is not 4. The rate codes are 0=2.5, 1=5, 2=8, 3=16 and 4=32 GT/s. A refusal gives a one-cycle `req_refused` pulse on the next cycle, the state does not change and `tx_os_type` stays 0.
- R2: A request made at rate 4 takes effect on the next cycle. A downstream port then advertises phase 1 and an upstream port advertises phase 0. Both send type code 1 (the first training ordered set). The type codes are 0=none, 1=TS0, 2=TS1, 3=TS2 and 4=idle.
- R3: An upstream port in phase 0 moves to phase 1 once `GOOD_RUN` consecutive received ordered sets carry `rx_os_good`. A received ordered set without `rx_os_good` restarts this count.
- R4: The controller acts on a far-side phase only after `MATCH_N` consecutive received ordered sets carry the same `rx_os_phase`. A different value restarts the run at one. Every change of the local state clears all run counters.
- R5: In phase 1 a downstream port moves to phase 2 on a confirmed far-side phase 1. An upstream port moves on a confirmed far-side phase 2. When `no_eq_local` and `no_eq_remote` are both high, a confirmed far-side phase 1 sends either role straight to the closing state and skips phases 2 and 3.
- R6: Phases 2 and 3 send type code 2. In phase 2 an upstream port advances when `sig_quality_ok` and `coef_accept` are both high. A downstream port in phase 2 advances on a confirmed far-side phase 3. Either role leaves phase 3 for the closing state when `sig_quality_ok` and `coef_accept` are both high.
- R7: After `WIN_CYC` cycles spent in phase 2, or in phase 3, without an exit, the controller returns to the recovery entry state. It then sends code 0 and advertises 0, and `eq_fail` pulses for one cycle. An exit condition on the last cycle of the window takes precedence over the timeout.
- R8: The closing state sends code 3 until `TS2_N` consecutive received ordered sets of type 3 have arrived. The idle state that follows sends code 4 for `IDLE_CYC` cycles. After that `eq_done` goes high and the output type returns to 0.
- R9: A request made while `eq_done` is high restarts equalization exactly as it would from the recovery entry state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_downstream | input | 1 | Role select: 1 = downstream, 0 = upstream |
| cur_rate | input | 3 | Current link rate code |
| eq_start | input | 1 | Equalization request strobe |
| no_eq_local | input | 1 | This port needs no equalization |
| no_eq_remote | input | 1 | Far port reported no equalization needed |
| rx_os_valid | input | 1 | One received ordered set this cycle |
| rx_os_phase | input | 2 | Phase advertised by that ordered set |
| rx_os_type | input | 3 | Type code of that ordered set |
| rx_os_good | input | 1 | That ordered set arrived without error |
| sig_quality_ok | input | 1 | Evaluated signal quality is acceptable |
| coef_accept | input | 1 | Requested coefficients were accepted |
| adv_phase | output | 2 | Phase value to advertise |
| tx_os_type | output | 3 | Ordered-set type code to transmit |
| eq_done | output | 1 | Operational state reached |
| eq_fail | output | 1 | One-cycle pulse on a window timeout |
| req_refused | output | 1 | One-cycle pulse on a refused request |

## Verification
On every cycle, the assertions check that requests at a lower rate are refused and that accepted requests enter the correct role-dependent phase. They also check that a skip never passes through phase 2 and that a downstream port never reaches phase 3 without a confirmed far-side phase 3. The remaining per-cycle checks are that every fail pulse lands in the recovery entry state and that completion follows the idle stretch. The bench's scenarios are needed to show behaviour over long stretches. This covers the run counts being restarted by a bad or disagreeing ordered set, the exact length of the timeout window, the full pass through both roles, and a restart from the operational state.

// File: rtl/eq_pkg.sv
package eq_pkg;
  localparam logic [2:0] RATE_32G = 3'd4;

  typedef enum logic [2:0] {
    OS_NONE = 3'd0,
    OS_TS0  = 3'd1,
    OS_TS1  = 3'd2,
    OS_TS2  = 3'd3,
    OS_IDLE = 3'd4
  } os_kind_t;

  typedef enum logic [2:0] {
    S_REC  = 3'd0,
    S_P0   = 3'd1,
    S_P1   = 3'd2,
    S_P2   = 3'd3,
    S_P3   = 3'd4,
    S_TS2  = 3'd5,
    S_IDLE = 3'd6,
    S_L0   = 3'd7
  } eq_state_t;
endpackage

// File: rtl/eq_run_cnt.sv
module eq_run_cnt #(
  parameter int RUN_N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic hit,
  output logic reached
);
  localparam int CW = $clog2(RUN_N + 1);
  localparam logic [CW-1:0] TOP = CW'(RUN_N);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (step && hit) cnt <= (cnt == TOP) ? TOP : cnt + 1'b1;
    else if (step)       cnt <= '0;
  end

  assign reached = (cnt == TOP);

  // A miss always breaks the run (R3)
  assert_miss_breaks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hit) |=> !reached)
    else $error("run counter kept its run after a miss");
endmodule

// File: rtl/eq_phase_filter.sv
module eq_phase_filter #(
  parameter int MATCH_N = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       os_vld,
  input  logic [1:0] os_phase,
  output logic       conf,
  output logic [1:0] conf_phase
);
  localparam int CW = $clog2(MATCH_N + 1);
  localparam logic [CW-1:0] TOP = CW'(MATCH_N);

  logic [CW-1:0] cnt;
  logic [1:0]    last_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      last_ph <= '0;
    end else if (clr) begin
      cnt     <= '0;
    end else if (os_vld) begin
      if (cnt != '0 && os_phase == last_ph)
        cnt <= (cnt == TOP) ? TOP : cnt + 1'b1;
      else begin
        cnt     <= CW'(1);
        last_ph <= os_phase;
      end
    end
  end

  assign conf       = (cnt == TOP);
  assign conf_phase = last_ph;

  // A disagreeing phase restarts the run (R4)
  assert_disagree_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (MATCH_N > 1 && os_vld && !clr && cnt != '0 && os_phase != last_ph) |=> !conf)
    else $error("phase confirmed across a disagreeing ordered set");
endmodule

// File: rtl/eq_cyc_timer.sv
module eq_cyc_timer #(
  parameter int LIMIT = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expire
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (run && !expire) cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == LAST);
endmodule

// File: rtl/eq_phase_ctrl.sv
module eq_phase_ctrl import eq_pkg::*; #(
  parameter int MATCH_N  = 4,
  parameter int GOOD_RUN = 8,
  parameter int TS2_N    = 8,
  parameter int IDLE_CYC = 16,
  parameter int WIN_CYC  = 48_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_downstream,
  input  logic [2:0] cur_rate,
  input  logic       eq_start,
  input  logic       no_eq_local,
  input  logic       no_eq_remote,
  input  logic       rx_os_valid,
  input  logic [1:0] rx_os_phase,
  input  logic [2:0] rx_os_type,
  input  logic       rx_os_good,
  input  logic       sig_quality_ok,
  input  logic       coef_accept,
  output logic [1:0] adv_phase,
  output logic [2:0] tx_os_type,
  output logic       eq_done,
  output logic       eq_fail,
  output logic       req_refused
);
  eq_state_t  state, nxt;
  logic       state_chg;
  logic       rem_conf;
  logic [1:0] rem_phase;
  logic       good_ok, ts2_ok, win_exp, idle_exp;
  logic       tune_ok, skip, idle_like, in_win;

  assign state_chg = (nxt != state);
  assign tune_ok   = sig_quality_ok && coef_accept;
  assign skip      = no_eq_local && no_eq_remote;
  assign idle_like = (state == S_REC) || (state == S_L0);
  assign in_win    = (state == S_P2) || (state == S_P3);

  eq_phase_filter #(.MATCH_N(MATCH_N)) u_filt (
    .clk(clk), .rst_n(rst_n), .clr(state_chg),
    .os_vld(rx_os_valid), .os_phase(rx_os_phase),
    .conf(rem_conf), .conf_phase(rem_phase)
  );

  eq_run_cnt #(.RUN_N(GOOD_RUN)) u_good (
    .clk(clk), .rst_n(rst_n), .clr(state_chg),
    .step(rx_os_valid), .hit(rx_os_good), .reached(good_ok)
  );

  eq_run_cnt #(.RUN_N(TS2_N)) u_ts2 (
    .clk(clk), .rst_n(rst_n), .clr(state_chg),
    .step(rx_os_valid), .hit(rx_os_type == OS_TS2), .reached(ts2_ok)
  );

  eq_cyc_timer #(.LIMIT(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(state_chg),
    .run(in_win), .expire(win_exp)
  );

  eq_cyc_timer #(.LIMIT(IDLE_CYC)) u_idle (
    .clk(clk), .rst_n(rst_n), .clr(state_chg),
    .run(state == S_IDLE), .expire(idle_exp)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      S_REC, S_L0: begin
        if (eq_start && cur_rate == RATE_32G)
          nxt = is_downstream ? S_P1 : S_P0;
      end
      S_P0: if (good_ok) nxt = S_P1;
      S_P1: begin
        if (rem_conf && rem_phase == 2'd1 && skip)                nxt = S_TS2;
        else if (is_downstream && rem_conf && rem_phase == 2'd1)  nxt = S_P2;
        else if (!is_downstream && rem_conf && rem_phase == 2'd2) nxt = S_P2;
      end
      S_P2: begin
        if (!is_downstream && tune_ok)                            nxt = S_P3;
        else if (is_downstream && rem_conf && rem_phase == 2'd3)  nxt = S_P3;
        else if (win_exp)                                         nxt = S_REC;
      end
      S_P3: begin
        if (tune_ok)      nxt = S_TS2;
        else if (win_exp) nxt = S_REC;
      end
      S_TS2:  if (ts2_ok)   nxt = S_IDLE;
      S_IDLE: if (idle_exp) nxt = S_L0;
      default: nxt = S_REC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_REC;
      eq_fail     <= 1'b0;
      req_refused <= 1'b0;
    end else begin
      state       <= nxt;
      eq_fail     <= in_win && (nxt == S_REC);
      req_refused <= idle_like && eq_start && (cur_rate != RATE_32G);
    end
  end

  always_comb begin
    adv_phase  = 2'd0;
    tx_os_type = OS_NONE;
    unique case (state)
      S_P0:   begin adv_phase = 2'd0; tx_os_type = OS_TS0; end
      S_P1:   begin adv_phase = 2'd1; tx_os_type = OS_TS0; end
      S_P2:   begin adv_phase = 2'd2; tx_os_type = OS_TS1; end
      S_P3:   begin adv_phase = 2'd3; tx_os_type = OS_TS1; end
      S_TS2:  tx_os_type = OS_TS2;
      S_IDLE: tx_os_type = OS_IDLE;
      default: ;
    endcase
  end

  assign eq_done = (state == S_L0);

  assert_refuse_low_rate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_like && eq_start && cur_rate != RATE_32G) |=> (req_refused && tx_os_type == OS_NONE))
    else $error("low-rate request not refused");

  assert_entry_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_like && eq_start && cur_rate == RATE_32G) |=>
      (tx_os_type == OS_TS0 && adv_phase == ($past(is_downstream) ? 2'd1 : 2'd0)))
    else $error("wrong entry phase");

  assert_skip_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_P1 && skip) |=> (state != S_P2))
    else $error("phase 2 entered although skipping");

  assert_ds_wait_far_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_P2 && is_downstream && !(rem_conf && rem_phase == 2'd3)) |=> (state != S_P3))
    else $error("downstream advanced without far-side phase 3");

  assert_fail_to_rec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eq_fail |-> (state == S_REC && tx_os_type == OS_NONE))
    else $error("fail pulse outside recovery entry");

  assert_done_after_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eq_done) |-> ($past(state) == S_IDLE))
    else $error("done without idle stretch");
endmodule

// File: tb/tb_eq_phase_ctrl.sv
module tb_eq_phase_ctrl;
  localparam int MN = 3, GR = 4, TN = 2, IC = 5, WC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_downstream = 1'b1;
  logic [2:0] cur_rate = 3'd4;
  logic eq_start = 1'b0, no_eq_local = 1'b0, no_eq_remote = 1'b0;
  logic rx_os_valid = 1'b0, rx_os_good = 1'b0;
  logic [1:0] rx_os_phase = 2'd0;
  logic [2:0] rx_os_type = 3'd0;
  logic sig_quality_ok = 1'b0, coef_accept = 1'b0;
  logic [1:0] adv_phase;
  logic [2:0] tx_os_type;
  logic eq_done, eq_fail, req_refused;

  always #10 clk = ~clk;

  eq_phase_ctrl #(.MATCH_N(MN), .GOOD_RUN(GR), .TS2_N(TN), .IDLE_CYC(IC), .WIN_CYC(WC)) dut (
    .clk(clk), .rst_n(rst_n), .is_downstream(is_downstream), .cur_rate(cur_rate),
    .eq_start(eq_start), .no_eq_local(no_eq_local), .no_eq_remote(no_eq_remote),
    .rx_os_valid(rx_os_valid), .rx_os_phase(rx_os_phase), .rx_os_type(rx_os_type),
    .rx_os_good(rx_os_good), .sig_quality_ok(sig_quality_ok), .coef_accept(coef_accept),
    .adv_phase(adv_phase), .tx_os_type(tx_os_type), .eq_done(eq_done),
    .eq_fail(eq_fail), .req_refused(req_refused)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  string tag = "reset";

  // behavioural model: 0 rec,1 p0,2 p1,3 p2,4 p3,5 closing,6 idle,7 operational
  int m_st = 0, m_pc = 0, m_pl = 0, m_gc = 0, m_tc = 0, m_wc = 0, m_ic = 0;
  int m_fail = 0, m_ref = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_pc = 0; m_pl = 0; m_gc = 0; m_tc = 0; m_wc = 0; m_ic = 0;
      m_fail = 0; m_ref = 0;
    end else begin
      int ns;
      bit conf, wexp, iexp, tune;
      conf = (m_pc == MN);
      wexp = (m_st == 3 || m_st == 4) && m_wc == WC - 1;
      iexp = (m_st == 6) && m_ic == IC - 1;
      tune = sig_quality_ok && coef_accept;
      ns = m_st;
      case (m_st)
        0, 7: if (eq_start && cur_rate == 4) ns = is_downstream ? 2 : 1;
        1: if (m_gc == GR) ns = 2;
        2: begin
          if (conf && m_pl == 1 && no_eq_local && no_eq_remote) ns = 5;
          else if (is_downstream && conf && m_pl == 1) ns = 3;
          else if (!is_downstream && conf && m_pl == 2) ns = 3;
        end
        3: begin
          if (!is_downstream && tune) ns = 4;
          else if (is_downstream && conf && m_pl == 3) ns = 4;
          else if (wexp) ns = 0;
        end
        4: if (tune) ns = 5; else if (wexp) ns = 0;
        5: if (m_tc == TN) ns = 6;
        6: if (iexp) ns = 7;
        default: ns = 0;
      endcase
      m_fail = ((m_st == 3 || m_st == 4) && ns == 0) ? 1 : 0;
      m_ref  = ((m_st == 0 || m_st == 7) && eq_start && cur_rate != 4) ? 1 : 0;
      if (ns != m_st) begin
        m_pc = 0; m_gc = 0; m_tc = 0; m_wc = 0; m_ic = 0;
      end else begin
        if (rx_os_valid) begin
          if (m_pc != 0 && rx_os_phase == m_pl) m_pc = (m_pc == MN) ? MN : m_pc + 1;
          else begin m_pc = 1; m_pl = rx_os_phase; end
          m_gc = rx_os_good ? ((m_gc == GR) ? GR : m_gc + 1) : 0;
          m_tc = (rx_os_type == 3) ? ((m_tc == TN) ? TN : m_tc + 1) : 0;
        end
        if ((m_st == 3 || m_st == 4) && !wexp) m_wc++;
        if (m_st == 6 && !iexp) m_ic++;
      end
      m_st = ns;
    end
  end

  function automatic int exp_adv(int s);
    case (s) 2: return 1; 3: return 2; 4: return 3; default: return 0; endcase
  endfunction
  function automatic int exp_tx(int s);
    case (s) 1, 2: return 1; 3, 4: return 2; 5: return 3; 6: return 4; default: return 0; endcase
  endfunction

  task automatic chk(string t, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", t, act, expv, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk({tag, " adv_phase"}, adv_phase, exp_adv(m_st));
      chk({tag, " tx_os_type"}, tx_os_type, exp_tx(m_st));
      chk({tag, " flags"}, {eq_done, eq_fail, req_refused},
          {m_st == 7, m_fail != 0, m_ref != 0});
    end
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic send(int ph, int typ, bit good);
    rx_os_valid = 1'b1; rx_os_phase = 2'(ph); rx_os_type = 3'(typ); rx_os_good = good;
    @(negedge clk);
    rx_os_valid = 1'b0;
  endtask
  task automatic start(int rate);
    cur_rate = 3'(rate); eq_start = 1'b1;
    @(negedge clk);
    eq_start = 1'b0;
  endtask
  task automatic tune_pulse();
    sig_quality_ok = 1'b1; coef_accept = 1'b1;
    @(negedge clk);
    sig_quality_ok = 1'b0; coef_accept = 1'b0;
  endtask
  task automatic close_out();
    repeat (TN) send(3, 3, 1'b1);
    tick(2);
    chk("R8 idle sent", tx_os_type, 4);
    tick(IC + 1);
    chk("R8 done", eq_done, 1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    chk("reset tx", tx_os_type, 0);
    chk("reset done", eq_done, 0);

    tag = "R1";
    for (int r = 0; r < 4; r++) begin
      start(r);
      chk("R1 refused pulse", req_refused, 1);
      chk("R1 stays silent", tx_os_type, 0);
    end

    tag = "R2 R4 R5 R6 R8 downstream";
    is_downstream = 1'b1;
    start(4);
    chk("R2 ds phase", adv_phase, 1);
    chk("R2 ds type", tx_os_type, 1);
    send(1, 1, 1); send(1, 1, 1); send(0, 1, 1); send(1, 1, 1); send(1, 1, 1);
    tick(2);
    chk("R4 disagree holds phase 1", adv_phase, 1);
    send(1, 1, 1); tick(2);
    chk("R5 ds to phase 2", adv_phase, 2);
    chk("R6 ts1 in phase 2", tx_os_type, 2);
    tune_pulse(); tick(1);
    chk("R6 ds ignores local tune in phase 2", adv_phase, 2);
    repeat (MN) send(3, 2, 1);
    tick(2);
    chk("R6 ds to phase 3", adv_phase, 3);
    tune_pulse(); tick(1);
    chk("R6 closing type", tx_os_type, 3);
    close_out();

    tag = "R9 R7 restart";
    start(4);
    chk("R9 restart from operational", adv_phase, 1);
    repeat (MN) send(1, 1, 1);
    tick(2);
    chk("R7 in window", adv_phase, 2);
    tick(WC - 4);
    chk("R7 still in window", adv_phase, 2);
    tick(4);
    chk("R7 timeout to entry", tx_os_type, 0);
    tick(3);

    tag = "R3 R5 R6 upstream";
    is_downstream = 1'b0;
    start(4);
    chk("R2 us phase", adv_phase, 0);
    send(0, 1, 1); send(0, 1, 1); send(0, 1, 0);
    repeat (GR - 1) send(0, 1, 1);
    tick(2);
    chk("R3 bad set restarts run", adv_phase, 0);
    send(0, 1, 1); tick(2);
    chk("R3 us to phase 1", adv_phase, 1);
    repeat (MN) send(1, 1, 1);
    tick(2);
    chk("R5 us waits for far phase 2", adv_phase, 1);
    repeat (MN) send(2, 2, 1);
    tick(2);
    chk("R5 us to phase 2", adv_phase, 2);
    tune_pulse(); tick(1);
    chk("R6 us to phase 3", adv_phase, 3);
    tick(WC + 2);
    chk("R7 phase 3 timeout", tx_os_type, 0);

    tag = "R5 skip";
    is_downstream = 1'b1; no_eq_local = 1'b1; no_eq_remote = 1'b1;
    start(4);
    repeat (MN) send(1, 1, 1);
    tick(2);
    chk("R5 skip to closing", tx_os_type, 3);
    no_eq_local = 1'b0; no_eq_remote = 1'b0;
    close_out();
    tick(3);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule